// File: doc/BRIEF.md
# Debug-State Injected Instruction Permission Checker

While a core is halted for debug, the debugger feeds it instructions one at a time. This block gives a verdict on each one before it takes effect. It looks at the core's current mode, its nonsecure bit and the two invasive-debug enables. For each instruction the verdict is one of three: execute it as issued, execute it but drop some field updates, or reject it as undefined. Instruction decode, register files and exception sequencing stay outside the block.

The caller supplies:
- an instruction class;
- for status-register writes, the proposed new mode and which privileged fields the write touches;
- for coprocessor accesses, the privilege level the target register needs.

The block returns the verdict and per-field write enables one cycle later, together with a done pulse. It also keeps a sticky undefined flag, which the debugger clears with a pulse.

Top module: `dbg_inject_guard`

## Requirements
- R1: Mode code 5'h10 is User and 5'h16 is Monitor. Every other code is privileged. The core counts as secure when ns_i is 0 or the mode is Monitor, whatever ns_i says. The verdict is encoded as 0 for execute, 1 for drop fields and 2 for undefined.
- R2: done_o pulses for exactly one cycle, in the cycle after req_valid_i is sampled high. verdict_o, mode_wr_en_o and aif_wr_en_o are valid while done_o is high.
- R3: A status-register write (iclass_i = 0) may update privileged fields only when privileged debug is allowed in the current security state. When secure, that needs dbgen_i and spiden_i. When nonsecure, it needs dbgen_i. If this is not allowed, both aif_wr_en_o and mode_wr_en_o are 0 and the verdict is drop.
- R4: For a status-register write, the mode-field update alone is dropped (verdict drop, never undefined) when debug is not allowed in the target mode. A target that is secure and privileged needs both enables; any other target needs dbgen_i. The target is secure when ns_i is 0 or the new mode is Monitor.
- R5: A secure-configuration-register write (iclass_i = 1) executes only in two cases: in a secure privileged mode (Monitor included), or in secure User mode with both enables high. In every other case it is undefined.
- R6: A secure-configuration-register write with ns_i = 1 in any mode other than Monitor is undefined, even when both enables are high.
- R7: A debug-coprocessor access (iclass_i = 2) with dbg_op_i = 1 always executes.
- R8: A debug-coprocessor access with dbg_op_i = 0, or a system-coprocessor access (iclass_i = 3), is checked against sys_lvl_i:
  - 0 always executes;
  - 1 executes if the mode is privileged or privileged debug is allowed as in R3;
  - 2 or 3 additionally needs the core to be secure (R1).
  
  Any other case is undefined.
- R9: The sticky flag is set together with done_o when the verdict is undefined. It holds until a sticky_clr_i pulse clears it on the next edge. A clear in the same cycle as an undefined verdict leaves it set. Reset clears it.
- R10: An undefined verdict, and any class other than status-register write, gives mode_wr_en_o = 0 and aif_wr_en_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Injected instruction present |
| iclass_i | input | 2 | Instruction class: 0 status write, 1 secure config write, 2 debug coproc, 3 system coproc |
| dbg_op_i | input | 1 | Debug-coprocessor access is a debug instruction |
| sys_lvl_i | input | 2 | Coprocessor register level: 0 open, 1 privileged, 2/3 secure privileged |
| mode_i | input | 5 | Current mode field |
| ns_i | input | 1 | Nonsecure bit |
| dbgen_i | input | 1 | Invasive debug enable |
| spiden_i | input | 1 | Secure invasive debug enable |
| new_mode_i | input | 5 | Proposed mode for a status-register write |
| mode_upd_i | input | 1 | Status write changes the mode field |
| aif_upd_i | input | 1 | Status write changes the A/I/F masks |
| sticky_clr_i | input | 1 | Clear pulse for the sticky flag |
| done_o | output | 1 | Verdict valid pulse |
| verdict_o | output | 2 | 0 execute, 1 drop fields, 2 undefined |
| mode_wr_en_o | output | 1 | Mode field may be written |
| aif_wr_en_o | output | 1 | A/I/F masks may be written |
| sticky_undef_o | output | 1 | Sticky undefined flag |

## Verification
Each verdict and its write enables are due on the first rising edge after the request is sampled. The sticky flag reaches its new value on that same edge.

The bench drives each request on a falling edge and compares all four outputs against its model on the next falling edge. One cycle later it checks that done_o has dropped again. In that same cycle it checks that the sticky flag holds unless a clear was pulsed. The sweep covers every mode code, both security states and all four enable combinations. At each point it issues every class and level. Directed cases cover a clear that coincides with a violation.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  localparam int unsigned MODE_W = 5;
  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_MON = 5'h16;

  typedef enum logic [1:0] {
    V_EXEC  = 2'd0,
    V_DROP  = 2'd1,
    V_UNDEF = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    C_PSR   = 2'd0,
    C_SCR   = 2'd1,
    C_DBGCP = 2'd2,
    C_SYSCP = 2'd3
  } iclass_e;

  typedef struct packed {
    logic cur_sec;
    logic cur_priv;
    logic priv_ok;
    logic tgt_ok;
  } ctx_t;
endpackage

// File: rtl/dbg_inject_ctx.sv
module dbg_inject_ctx
  import dbg_inject_pkg::*;
#(
  parameter int unsigned               MW       = MODE_W,
  parameter logic [MW-1:0]             USR_CODE = MODE_USR,
  parameter logic [MW-1:0]             MON_CODE = MODE_MON
) (
  input  logic [MW-1:0] mode_i,
  input  logic [MW-1:0] new_mode_i,
  input  logic          ns_i,
  input  logic          dbgen_i,
  input  logic          spiden_i,
  output ctx_t          ctx_o
);
  logic full_en, tgt_sec, tgt_priv;

  assign full_en = dbgen_i & spiden_i;

  // Monitor is secure regardless of ns
  assign ctx_o.cur_sec  = ~ns_i | (mode_i == MON_CODE);
  assign ctx_o.cur_priv = (mode_i != USR_CODE);
  assign ctx_o.priv_ok  = ctx_o.cur_sec ? full_en : dbgen_i;

  assign tgt_sec  = ~ns_i | (new_mode_i == MON_CODE);
  assign tgt_priv = (new_mode_i != USR_CODE);
  assign ctx_o.tgt_ok = (tgt_sec & tgt_priv) ? full_en : dbgen_i;
endmodule

// File: rtl/dbg_inject_rule.sv
module dbg_inject_rule
  import dbg_inject_pkg::*;
(
  input  ctx_t       ctx_i,
  input  logic [1:0] iclass_i,
  input  logic       dbg_op_i,
  input  logic [1:0] sys_lvl_i,
  input  logic       mode_upd_i,
  input  logic       aif_upd_i,
  output verdict_e   verdict_o,
  output logic       mode_wr_o,
  output logic       aif_wr_o
);
  logic sec_ok, sys_ok;

  assign sec_ok = ctx_i.cur_sec & (ctx_i.cur_priv | ctx_i.priv_ok);

  always_comb begin
    unique case (sys_lvl_i)
      2'd0:    sys_ok = 1'b1;
      2'd1:    sys_ok = ctx_i.cur_priv | ctx_i.priv_ok;
      default: sys_ok = sec_ok;
    endcase
  end

  always_comb begin
    verdict_o = V_EXEC;
    mode_wr_o = 1'b0;
    aif_wr_o  = 1'b0;
    unique case (iclass_i)
      C_PSR: begin
        aif_wr_o  = aif_upd_i & ctx_i.priv_ok;
        mode_wr_o = mode_upd_i & ctx_i.priv_ok & ctx_i.tgt_ok;
        if ((aif_upd_i & ~aif_wr_o) | (mode_upd_i & ~mode_wr_o))
          verdict_o = V_DROP;
      end
      C_SCR: if (!sec_ok) verdict_o = V_UNDEF;
      C_DBGCP: if (!dbg_op_i && !sys_ok) verdict_o = V_UNDEF;
      default: if (!sys_ok) verdict_o = V_UNDEF;
    endcase
  end
endmodule

// File: rtl/dbg_inject_sticky.sv
module dbg_inject_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/dbg_inject_guard.sv
module dbg_inject_guard
  import dbg_inject_pkg::*;
#(
  parameter int unsigned   MW       = MODE_W,
  parameter logic [MW-1:0] USR_CODE = MODE_USR,
  parameter logic [MW-1:0] MON_CODE = MODE_MON
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    iclass_i,
  input  logic          dbg_op_i,
  input  logic [1:0]    sys_lvl_i,
  input  logic [MW-1:0] mode_i,
  input  logic          ns_i,
  input  logic          dbgen_i,
  input  logic          spiden_i,
  input  logic [MW-1:0] new_mode_i,
  input  logic          mode_upd_i,
  input  logic          aif_upd_i,
  input  logic          sticky_clr_i,
  output logic          done_o,
  output logic [1:0]    verdict_o,
  output logic          mode_wr_en_o,
  output logic          aif_wr_en_o,
  output logic          sticky_undef_o
);
  ctx_t     ctx;
  verdict_e verdict_d;
  logic     mode_wr_d, aif_wr_d;

  dbg_inject_ctx #(.MW(MW), .USR_CODE(USR_CODE), .MON_CODE(MON_CODE)) u_ctx (
    .mode_i     (mode_i),
    .new_mode_i (new_mode_i),
    .ns_i       (ns_i),
    .dbgen_i    (dbgen_i),
    .spiden_i   (spiden_i),
    .ctx_o      (ctx)
  );

  dbg_inject_rule u_rule (
    .ctx_i      (ctx),
    .iclass_i   (iclass_i),
    .dbg_op_i   (dbg_op_i),
    .sys_lvl_i  (sys_lvl_i),
    .mode_upd_i (mode_upd_i),
    .aif_upd_i  (aif_upd_i),
    .verdict_o  (verdict_d),
    .mode_wr_o  (mode_wr_d),
    .aif_wr_o   (aif_wr_d)
  );

  dbg_inject_sticky u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_valid_i && (verdict_d == V_UNDEF)),
    .clr_i  (sticky_clr_i),
    .flag_o (sticky_undef_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      verdict_o    <= V_EXEC;
      mode_wr_en_o <= 1'b0;
      aif_wr_en_o  <= 1'b0;
    end else begin
      done_o <= req_valid_i;
      if (req_valid_i) begin
        verdict_o    <= verdict_d;
        mode_wr_en_o <= mode_wr_d;
        aif_wr_en_o  <= aif_wr_d;
      end
    end
  end
endmodule

// File: rtl/dbg_inject_guard_chk.sv
module dbg_inject_guard_chk
  import dbg_inject_pkg::*;
#(
  parameter int unsigned   MW       = MODE_W,
  parameter logic [MW-1:0] MON_CODE = MODE_MON
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    iclass_i,
  input logic          dbg_op_i,
  input logic [MW-1:0] mode_i,
  input logic          ns_i,
  input logic          sticky_clr_i,
  input logic          done_o,
  input logic [1:0]    verdict_o,
  input logic          mode_wr_en_o,
  input logic          aif_wr_en_o,
  input logic          sticky_undef_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_done_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    done_o == $past(req_valid_i));

  p_dbg_op_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && iclass_i == C_DBGCP && dbg_op_i |=> verdict_o == V_EXEC);

  p_scr_nonsec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && iclass_i == C_SCR && ns_i && mode_i != MON_CODE |=> verdict_o == V_UNDEF);

  p_undef_no_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && verdict_o == V_UNDEF |-> !mode_wr_en_o && !aif_wr_en_o);

  p_undef_sets_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && verdict_o == V_UNDEF |-> sticky_undef_o);

  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(sticky_undef_o) && !$past(sticky_clr_i) |-> sticky_undef_o);

  p_sticky_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(sticky_clr_i) && !(done_o && verdict_o == V_UNDEF) |-> !sticky_undef_o);
endmodule

bind dbg_inject_guard dbg_inject_guard_chk #(.MW(MW), .MON_CODE(MON_CODE)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .iclass_i       (iclass_i),
  .dbg_op_i       (dbg_op_i),
  .mode_i         (mode_i),
  .ns_i           (ns_i),
  .sticky_clr_i   (sticky_clr_i),
  .done_o         (done_o),
  .verdict_o      (verdict_o),
  .mode_wr_en_o   (mode_wr_en_o),
  .aif_wr_en_o    (aif_wr_en_o),
  .sticky_undef_o (sticky_undef_o)
);

// File: tb/dbg_inject_guard_bench.sv
module dbg_inject_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, dbg_op = 1'b0, ns = 1'b0, de = 1'b0, se = 1'b0;
  logic       mupd = 1'b0, aupd = 1'b0, clr = 1'b0;
  logic [1:0] cls = 2'd0, lvl = 2'd0;
  logic [4:0] mode = 5'h10, nmode = 5'h10;
  logic       done, mwr, awr, sticky;
  logic [1:0] verd;

  int checks = 0;
  int errors = 0;
  int op_cnt = 0;
  bit exp_sticky = 1'b0;

  always #2.5 clk = ~clk;

  dbg_inject_guard u_dbg_inject_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .iclass_i(cls),
    .dbg_op_i(dbg_op), .sys_lvl_i(lvl), .mode_i(mode), .ns_i(ns),
    .dbgen_i(de), .spiden_i(se), .new_mode_i(nmode), .mode_upd_i(mupd),
    .aif_upd_i(aupd), .sticky_clr_i(clr), .done_o(done), .verdict_o(verd),
    .mode_wr_en_o(mwr), .aif_wr_en_o(awr), .sticky_undef_o(sticky)
  );

  // Reference: returns {verdict[1:0], mode_wr, aif_wr}
  function automatic logic [3:0] ref_model(logic [4:0] m, logic n, logic d, logic s,
      logic [1:0] c, logic op, logic [1:0] lv, logic [4:0] nm, logic mu, logic au);
    bit is_mon = (m == 5'h16);
    bit is_usr = (m == 5'h10);
    bit secure = !n || is_mon;                       // R1
    bit both   = d && s;
    bit can_priv = secure ? both : d;
    bit secpriv  = secure && (!is_usr || both);
    bit t_sec, t_priv, t_ok, a, mw, ok;
    logic [1:0] v;
    if (c == 2'd0) begin
      t_sec  = !n || (nm == 5'h16);
      t_priv = (nm != 5'h10);
      t_ok   = (t_sec && t_priv) ? both : d;
      a  = au && can_priv;
      mw = mu && can_priv && t_ok;
      v  = ((au && !a) || (mu && !mw)) ? 2'd1 : 2'd0;
      return {v, mw, a};
    end
    if (c == 2'd1) ok = secpriv;
    else if (c == 2'd2 && op) ok = 1'b1;
    else if (lv == 2'd0) ok = 1'b1;
    else if (lv == 2'd1) ok = !is_usr || can_priv;
    else ok = secpriv;
    return {(ok ? 2'd0 : 2'd2), 2'b00};
  endfunction

  function automatic string req_of(logic [1:0] c, logic op);
    case (c)
      2'd0: return "R3/R4";
      2'd1: return "R5/R6";
      2'd2: return op ? "R7" : "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] c, logic op, logic [1:0] lv, logic [4:0] nm,
                        logic mu, logic au, logic cl);
    logic [3:0] e;
    @(negedge clk);
    cls = c; dbg_op = op; lvl = lv; nmode = nm; mupd = mu; aupd = au;
    clr = cl; valid = 1'b1;
    e = ref_model(mode, ns, de, se, c, op, lv, nm, mu, au);
    exp_sticky = (e[3:2] == 2'd2) || (exp_sticky && !cl);
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
    chk("R2 done", {31'd0, done}, 32'd1);
    chk(req_of(c, op), {28'd0, verd, mwr, awr}, {28'd0, e});
    if (e[3:2] == 2'd2 || c != 2'd0) chk("R10 no write", {30'd0, mwr, awr}, 32'd0);
    chk("R9 sticky", {31'd0, sticky}, {31'd0, exp_sticky});
    @(negedge clk);
    chk("R2 done drop", {31'd0, done}, 32'd0);
    chk("R9 sticky hold", {31'd0, sticky}, {31'd0, exp_sticky});
    op_cnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset sticky", {31'd0, sticky}, 32'd0);
    chk("R2 reset done", {31'd0, done}, 32'd0);

    // Directed R9: violation plus clear in same cycle keeps flag, lone clear drops it
    mode = 5'h10; ns = 1'b1; de = 1'b1; se = 1'b1;
    run_op(2'd1, 1'b0, 2'd0, 5'h10, 1'b0, 1'b0, 1'b1);
    chk("R9 set with clear", {31'd0, sticky}, 32'd1);
    run_op(2'd0, 1'b0, 2'd0, 5'h10, 1'b0, 1'b0, 1'b1);
    chk("R9 cleared", {31'd0, sticky}, 32'd0);
    // Directed R6: nonsecure privileged mode, both enables, SCR write undefined
    mode = 5'h13;
    run_op(2'd1, 1'b0, 2'd0, 5'h10, 1'b0, 1'b0, 1'b0);
    chk("R6 ns scr", {30'd0, verd}, 32'd2);
    // Directed R1/R5: Monitor with ns=1 is secure privileged
    mode = 5'h16;
    run_op(2'd1, 1'b0, 2'd0, 5'h10, 1'b0, 1'b0, 1'b1);
    chk("R1 monitor secure", {30'd0, verd}, 32'd0);

    for (int m = 0; m < 32; m++) begin
      for (int k = 0; k < 8; k++) begin
        mode = 5'(m); ns = k[0]; de = k[1]; se = k[2];
        for (int t = 0; t < 3; t++) begin
          logic [4:0] tm;
          tm = (t == 0) ? 5'h10 : (t == 1) ? 5'h16 : 5'h13;
          for (int u = 0; u < 4; u++)
            run_op(2'd0, 1'b0, 2'd0, tm, u[0], u[1], (op_cnt % 7) == 3);
        end
        run_op(2'd1, 1'b0, 2'd0, 5'h10, 1'b0, 1'b0, (op_cnt % 7) == 3);
        run_op(2'd2, 1'b1, 2'd3, 5'h10, 1'b0, 1'b0, (op_cnt % 7) == 3);
        for (int l = 0; l < 4; l++) begin
          run_op(2'd2, 1'b0, 2'(l), 5'h10, 1'b0, 1'b0, (op_cnt % 7) == 3);
          run_op(2'd3, 1'b0, 2'(l), 5'h10, 1'b0, 1'b0, (op_cnt % 7) == 3);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule